// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter

This block lets a processor port and a peripheral port share one single-ported synchronous memory bank. Each port presents read and write strobes, an address and write data, and gets back read data and a stall flag. A window decoder splits the processor's address space. Addresses inside a parameterised shared window go to the shared bank. All other processor addresses go to a private bank that the peripheral cannot reach. Only shared-window traffic is arbitrated, so private processor accesses never stall.

The shared bank serves at most one access per cycle. When both ports want it in the same cycle, one is served and the other sees its stall flag raised in that same cycle. The ports take turns: the port that was not served most recently wins a conflict.

Back-pressure works as a ready signal. A requester holds its strobes, address and data steady while its stall flag is high. The request is accepted in the first cycle whose flag is low. A peripheral address outside the window is rejected with an error flag in that cycle and touches no storage.

Top module: `shmem_arbiter`

## Requirements
- R1: A processor read or write whose address is outside the shared window goes to the private bank and never raises `cpu_wait`. Private read data appears on `cpu_rdata` in the next cycle, and a private write is stored at the clock edge.
- R2: A read or write inside the window from only one port is accepted in its own cycle, with that port's wait flag low.
- R3: When both ports request inside the window in the same cycle, exactly one is accepted and the other's wait flag is high. The accepted port is the one not accepted most recently. The last-served port is kept across idle cycles. After reset the peripheral counts as last served, so the processor wins the first conflict.
- R4: A wait flag is high only in a cycle where its own port requests inside the window and loses. A port that lost and holds its request is accepted in the very next cycle, with its wait flag low.
- R5: Read data for an accepted shared read appears on the port's rdata in the cycle after acceptance. A read returns the word as stored before any write in the same cycle. An accepted write is stored at that cycle's clock edge, and either port can read it from the next cycle on.
- R6: A peripheral read or write outside the window raises `io_err` in the same cycle and keeps `io_wait` low. It changes neither bank: a write to the word just above the window leaves shared word 0 unchanged.
- R7: The window covers addresses SH_BASE to SH_BASE+SH_WORDS-1 inclusive (0x40 to 0x4F by default). Both ends belong to the shared bank. For the processor, SH_BASE-1 and SH_BASE+SH_WORDS belong to the private bank.
- R8: During and right after reset, with idle inputs, `cpu_wait`, `io_wait` and `io_err` are low and both rdata outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data, valid the cycle after acceptance |
| cpu_wait | output | 1 | Processor stall: request not accepted this cycle |
| io_rd | input | 1 | Peripheral read strobe |
| io_wr | input | 1 | Peripheral write strobe |
| io_addr | input | AW | Peripheral word address |
| io_wdata | input | DW | Peripheral write data |
| io_rdata | output | DW | Peripheral read data, valid the cycle after acceptance |
| io_wait | output | 1 | Peripheral stall: request not accepted this cycle |
| io_err | output | 1 | Peripheral address outside the shared window |

## Verification
The main function is tried with four kinds of traffic. Lone requests from each port show that no stall is invented. Simultaneous requests, each followed by the loser retrying, show the alternation. Mixed private and shared traffic shows that the decoder keeps processor private accesses clear of the arbiter. Accesses on and just beyond both window edges show that the bounds are inclusive and that a rejected peripheral access leaves storage alone. The conflicts follow runs of peripheral wins, processor wins and idle gaps, so the rotation is told apart from a fixed priority. A reset in the middle of traffic shows where the turn-taking restarts.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  typedef enum logic {
    OWNER_CPU = 1'b0,
    OWNER_IO  = 1'b1
  } owner_e;

  localparam int PORT_CPU = 0;
  localparam int PORT_IO  = 1;
  localparam int NPORTS   = 2;
endpackage

// File: rtl/shmem_window.sv
module shmem_window #(
  parameter int AW    = 8,
  parameter int BASE  = 64,
  parameter int WORDS = 16,
  parameter int OW    = 4
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [OW-1:0] offset
);
  localparam logic [AW:0]   LO   = (AW+1)'(BASE);
  localparam logic [AW:0]   HI   = (AW+1)'(BASE + WORDS);
  localparam logic [AW-1:0] LO_A = AW'(BASE);

  logic [AW:0] addr_x;
  assign addr_x = {1'b0, addr};
  assign hit    = (addr_x >= LO) && (addr_x < HI);
  assign offset = OW'(addr - LO_A);
endmodule

// File: rtl/shmem_bank.sv
module shmem_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [IW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (en) rdata <= mem[addr];
  end
endmodule

// File: rtl/shmem_turn_arb.sv
module shmem_turn_arb
  import shmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_cpu,
  input  logic req_io,
  output logic gnt_cpu,
  output logic gnt_io
);
  owner_e last_q;

  always_comb begin
    gnt_cpu = 1'b0;
    gnt_io  = 1'b0;
    if (req_cpu && req_io) begin
      if (last_q == OWNER_IO) gnt_cpu = 1'b1;
      else                    gnt_io  = 1'b1;
    end else begin
      gnt_cpu = req_cpu;
      gnt_io  = req_io;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= OWNER_IO;
    else if (gnt_cpu) last_q <= OWNER_CPU;
    else if (gnt_io)  last_q <= OWNER_IO;
  end
endmodule

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int SH_BASE  = 64,
  parameter int SH_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_wait,
  input  logic          io_rd,
  input  logic          io_wr,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_wait,
  output logic          io_err
);
  localparam int SH_IW      = (SH_WORDS > 1) ? $clog2(SH_WORDS) : 1;
  localparam int PRIV_DEPTH = 1 << AW;

  logic [AW-1:0]    port_addr [NPORTS];
  logic             port_hit  [NPORTS];
  logic [SH_IW-1:0] port_off  [NPORTS];

  assign port_addr[PORT_CPU] = cpu_addr;
  assign port_addr[PORT_IO]  = io_addr;

  for (genvar p = 0; p < NPORTS; p++) begin : g_dec
    shmem_window #(
      .AW(AW), .BASE(SH_BASE), .WORDS(SH_WORDS), .OW(SH_IW)
    ) u_win (
      .addr  (port_addr[p]),
      .hit   (port_hit[p]),
      .offset(port_off[p])
    );
  end

  logic cpu_req, io_req, cpu_sh, io_sh, cpu_priv;
  logic gnt_cpu, gnt_io;

  assign cpu_req  = cpu_rd | cpu_wr;
  assign io_req   = io_rd | io_wr;
  assign cpu_sh   = cpu_req & port_hit[PORT_CPU];
  assign cpu_priv = cpu_req & ~port_hit[PORT_CPU];
  assign io_sh    = io_req & port_hit[PORT_IO];

  shmem_turn_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_cpu(cpu_sh),
    .req_io (io_sh),
    .gnt_cpu(gnt_cpu),
    .gnt_io (gnt_io)
  );

  assign cpu_wait = cpu_sh & ~gnt_cpu;
  assign io_wait  = io_sh & ~gnt_io;
  assign io_err   = io_req & ~port_hit[PORT_IO];

  logic             sh_en, sh_we;
  logic [SH_IW-1:0] sh_addr;
  logic [DW-1:0]    sh_wdata, sh_rdata, priv_rdata;

  assign sh_en    = gnt_cpu | gnt_io;
  assign sh_we    = gnt_cpu ? cpu_wr : io_wr;
  assign sh_addr  = gnt_cpu ? port_off[PORT_CPU] : port_off[PORT_IO];
  assign sh_wdata = gnt_cpu ? cpu_wdata : io_wdata;

  shmem_bank #(.DW(DW), .DEPTH(SH_WORDS), .IW(SH_IW)) u_shared (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (sh_en),
    .we   (sh_we),
    .addr (sh_addr),
    .wdata(sh_wdata),
    .rdata(sh_rdata)
  );

  shmem_bank #(.DW(DW), .DEPTH(PRIV_DEPTH), .IW(AW)) u_private (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cpu_priv),
    .we   (cpu_wr),
    .addr (cpu_addr),
    .wdata(cpu_wdata),
    .rdata(priv_rdata)
  );

  logic cpu_from_sh_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        cpu_from_sh_q <= 1'b0;
    else if (gnt_cpu)  cpu_from_sh_q <= 1'b1;
    else if (cpu_priv) cpu_from_sh_q <= 1'b0;
  end

  assign cpu_rdata = cpu_from_sh_q ? sh_rdata : priv_rdata;
  assign io_rdata  = sh_rdata;
endmodule

// File: rtl/shmem_arbiter_chk.sv
module shmem_arbiter_chk #(
  parameter int AW       = 8,
  parameter int SH_BASE  = 64,
  parameter int SH_WORDS = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_wait,
  input logic          io_rd,
  input logic          io_wr,
  input logic [AW-1:0] io_addr,
  input logic          io_wait,
  input logic          io_err
);
  logic cpu_in, io_in, c_sh, i_sh, both;
  assign cpu_in = (int'(cpu_addr) >= SH_BASE) && (int'(cpu_addr) < SH_BASE + SH_WORDS);
  assign io_in  = (int'(io_addr)  >= SH_BASE) && (int'(io_addr)  < SH_BASE + SH_WORDS);
  assign c_sh   = (cpu_rd | cpu_wr) & cpu_in;
  assign i_sh   = (io_rd | io_wr) & io_in;
  assign both   = c_sh & i_sh;

  AST_PRIV_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_rd | cpu_wr) && !cpu_in) |-> !cpu_wait); // R1
  AST_SOLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (c_sh != i_sh) |-> (!cpu_wait && !io_wait)); // R2
  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> (cpu_wait != io_wait)); // R3
  AST_TURN_IO: assert property (@(posedge clk) disable iff (!rst_n)
    (both && io_wait) |=> (!both || cpu_wait)); // R3
  AST_TURN_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (both && cpu_wait) |=> (!both || io_wait)); // R3
  AST_WAIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait |-> c_sh) and (io_wait |-> i_sh)); // R4
  AST_CPU_RETRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |=> (!c_sh || !cpu_wait)); // R4
  AST_IO_RETRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    io_wait |=> (!i_sh || !io_wait)); // R4
  AST_ERR_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    io_err |-> (!io_wait && (io_rd | io_wr) && !io_in)); // R6
endmodule

bind shmem_arbiter shmem_arbiter_chk #(
  .AW(AW), .SH_BASE(SH_BASE), .SH_WORDS(SH_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wait(cpu_wait),
  .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wait(io_wait), .io_err(io_err)
);

// File: tb/shmem_arbiter_tb.sv
`timescale 1ns/1ps
module shmem_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 0, cpu_wr = 0, io_rd = 0, io_wr = 0;
  logic [7:0]  cpu_addr = '0, io_addr = '0;
  logic [15:0] cpu_wdata = '0, io_wdata = '0;
  logic [15:0] cpu_rdata, io_rdata;
  logic        cpu_wait, io_wait, io_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shmem_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .io_wait(io_wait), .io_err(io_err)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        crd, cwr;
    logic [7:0]  ca;
    logic [15:0] cd;
    logic        ird, iwr;
    logic [7:0]  ia;
    logic [15:0] id;
    logic        ecw, eiw, eer;
    logic        ckc;
    logic [15:0] ecr;
    logic        cki;
    logic [15:0] eir;
  } vec_t;

  localparam int NV = 16;
  // Window is 0x40..0x4F. After reset the peripheral counts as last served.
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b0,1'b1,8'h10,16'hA001, 1'b0,1'b0,8'h00,16'h0000, 1'b0,1'b0,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R1 private write
    '{4'd1, 1'b1,1'b0,8'h10,16'h0000, 1'b0,1'b1,8'h40,16'hB001, 1'b0,1'b0,1'b0, 1'b1,16'hA001, 1'b0,16'h0000}, // R1 private read, R2 io write
    '{4'd7, 1'b0,1'b1,8'h4F,16'hC00F, 1'b0,1'b0,8'h00,16'h0000, 1'b0,1'b0,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R7 top edge shared
    '{4'd3, 1'b1,1'b0,8'h40,16'h0000, 1'b1,1'b0,8'h4F,16'h0000, 1'b1,1'b0,1'b0, 1'b0,16'h0000, 1'b1,16'hC00F}, // R3 io wins, R5
    '{4'd4, 1'b1,1'b0,8'h40,16'h0000, 1'b0,1'b1,8'h41,16'hD041, 1'b0,1'b1,1'b0, 1'b1,16'hB001, 1'b0,16'h0000}, // R4 cpu retry wins
    '{4'd4, 1'b0,1'b0,8'h00,16'h0000, 1'b0,1'b1,8'h41,16'hD041, 1'b0,1'b0,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R4 io retry
    '{4'd5, 1'b1,1'b0,8'h41,16'h0000, 1'b1,1'b0,8'h41,16'h0000, 1'b0,1'b1,1'b0, 1'b1,16'hD041, 1'b0,16'h0000}, // R5 write seen
    '{4'd7, 1'b0,1'b1,8'h3F,16'hE03F, 1'b1,1'b0,8'h41,16'h0000, 1'b0,1'b0,1'b0, 1'b0,16'h0000, 1'b1,16'hD041}, // R7 base-1 private
    '{4'd6, 1'b0,1'b1,8'h50,16'hF050, 1'b0,1'b1,8'h50,16'h9999, 1'b0,1'b0,1'b1, 1'b0,16'h0000, 1'b0,16'h0000}, // R6 io out of window
    '{4'd6, 1'b1,1'b0,8'h3F,16'h0000, 1'b1,1'b0,8'h40,16'h0000, 1'b0,1'b0,1'b0, 1'b1,16'hE03F, 1'b1,16'hB001}, // R6 word 0 intact
    '{4'd7, 1'b1,1'b0,8'h50,16'h0000, 1'b1,1'b0,8'h4F,16'h0000, 1'b0,1'b0,1'b0, 1'b1,16'hF050, 1'b1,16'hC00F}, // R7 limit private
    '{4'd3, 1'b0,1'b1,8'h42,16'h1234, 1'b0,1'b1,8'h43,16'h5678, 1'b0,1'b1,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R3 cpu wins
    '{4'd3, 1'b1,1'b0,8'h42,16'h0000, 1'b0,1'b1,8'h43,16'h5678, 1'b1,1'b0,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}, // R3 io wins
    '{4'd3, 1'b1,1'b0,8'h42,16'h0000, 1'b1,1'b0,8'h43,16'h0000, 1'b0,1'b1,1'b0, 1'b1,16'h1234, 1'b0,16'h0000}, // R3 cpu wins
    '{4'd5, 1'b0,1'b0,8'h00,16'h0000, 1'b1,1'b0,8'h43,16'h0000, 1'b0,1'b0,1'b0, 1'b0,16'h0000, 1'b1,16'h5678}, // R5 io read
    '{4'd2, 1'b0,1'b0,8'h00,16'h0000, 1'b0,1'b0,8'h00,16'h0000, 1'b0,1'b0,1'b0, 1'b0,16'h0000, 1'b0,16'h0000}  // R2 idle
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic crd, cwr, input logic [7:0] ca, input logic [15:0] cd,
                       input logic ird, iwr, input logic [7:0] ia, input logic [15:0] id);
    cpu_rd = crd; cpu_wr = cwr; cpu_addr = ca; cpu_wdata = cd;
    io_rd = ird; io_wr = iwr; io_addr = ia; io_wdata = id;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic pc, pi;
    logic [15:0] ec, ei;
    string rq;
    pc = 0; pi = 0; ec = '0; ei = '0; rq = "";

    repeat (3) @(negedge clk);
    chk("R8", "cpu_rdata in reset", cpu_rdata, 16'h0);
    chk("R8", "io_rdata in reset", io_rdata, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    chk("R8", "cpu_wait after reset", {15'b0, cpu_wait}, 16'h0);
    chk("R8", "io_wait after reset", {15'b0, io_wait}, 16'h0);
    chk("R8", "io_err after reset", {15'b0, io_err}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (pc) chk(rq, "cpu_rdata", cpu_rdata, ec);
      if (pi) chk(rq, "io_rdata", io_rdata, ei);
      rq = $sformatf("R%0d", VEC[i].tag);
      drive(VEC[i].crd, VEC[i].cwr, VEC[i].ca, VEC[i].cd,
            VEC[i].ird, VEC[i].iwr, VEC[i].ia, VEC[i].id);
      #3;
      chk(rq, $sformatf("cpu_wait v%0d", i), {15'b0, cpu_wait}, {15'b0, VEC[i].ecw});
      chk(rq, $sformatf("io_wait v%0d", i), {15'b0, io_wait}, {15'b0, VEC[i].eiw});
      chk(rq, $sformatf("io_err v%0d", i), {15'b0, io_err}, {15'b0, VEC[i].eer});
      pc = VEC[i].ckc; ec = VEC[i].ecr;
      pi = VEC[i].cki; ei = VEC[i].eir;
    end
    @(negedge clk);
    if (pc) chk(rq, "cpu_rdata", cpu_rdata, ec);
    if (pi) chk(rq, "io_rdata", io_rdata, ei);

    // R8: reset mid-run clears rdata, processor wins first conflict (R3)
    rst_n = 1'b0;
    drive(0, 0, 8'h00, 16'h0, 0, 0, 8'h00, 16'h0);
    @(negedge clk);
    @(negedge clk);
    chk("R8", "cpu_rdata after reset", cpu_rdata, 16'h0);
    chk("R8", "io_rdata after reset", io_rdata, 16'h0);
    rst_n = 1'b1;
    drive(0, 1, 8'h44, 16'h4444, 0, 1, 8'h45, 16'h4545);
    #3;
    chk("R3", "cpu_wait first conflict", {15'b0, cpu_wait}, 16'h0);
    chk("R3", "io_wait first conflict", {15'b0, io_wait}, 16'h1);

    // R1: private processor read while peripheral uses the shared bank
    @(negedge clk);
    drive(1, 0, 8'h10, 16'h0, 0, 1, 8'h45, 16'h4545);
    #3;
    chk("R1", "cpu_wait private vs io", {15'b0, cpu_wait}, 16'h0);
    chk("R4", "io_wait retry", {15'b0, io_wait}, 16'h0);
    @(negedge clk);
    chk("R1", "cpu_rdata private", cpu_rdata, 16'hA001);

    // R6: peripheral below the window
    drive(1, 0, 8'h44, 16'h0, 1, 0, 8'h00, 16'h0);
    #3;
    chk("R6", "io_err below window", {15'b0, io_err}, 16'h1);
    chk("R6", "io_wait below window", {15'b0, io_wait}, 16'h0);
    chk("R2", "cpu_wait lone shared", {15'b0, cpu_wait}, 16'h0);
    @(negedge clk);
    chk("R5", "cpu_rdata 0x44", cpu_rdata, 16'h4444);
    drive(0, 0, 8'h00, 16'h0, 1, 0, 8'h45, 16'h0);
    @(negedge clk);
    chk("R5", "io_rdata 0x45", io_rdata, 16'h4545);
    drive(0, 0, 8'h00, 16'h0, 0, 0, 8'h00, 16'h0);
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule